// File: doc/BRIEF.md
# Interrupt-Aware Processor Status Register

This block keeps the processor status word and applies the hardware updates made on entry to exception and interrupt handlers. A noninterrupt exception, a break and an accepted external interrupt each copy the live word into a saved-status register. Each also records the index of the register set in use in a previous-set field, and then adjusts the mode bits and the current set index. A return strobe copies the saved word back in one cycle. Software can write either word through a single write port.

The block also decides whether an external interrupt request may be taken. It compares the request against the interrupt enable, a level threshold and a register-set enable. The decision is a combinational output, so the pipeline can redirect in the same cycle. The same decision drives the entry update at the next clock edge. The number of register sets and the width of the level field are parameters. A parameter also chooses whether the user and exception-mode bits exist.

Top module: `psr_unit`

## Requirements
- R1: After a synchronous reset the live word reads 0x0080_0000, with only the set-enable bit (bit 23) at 1. The saved word reads 0, and `irq_take_o` is 0 while no request is present.
- R2: A request whose nonmaskable flag is 0 is taken only when the interrupt-enable bit (bit 0) is 1 and `irq_lvl_i` is strictly greater than the threshold field (bits starting at 4).
- R3: When the set-enable bit (bit 23) is 0, a request naming the set equal to the current-set field (bits starting at 10) is refused. This also applies to nonmaskable requests.
- R4: A request with `irq_nmi_i` = 1 is taken whatever the values of the interrupt-enable bit and the threshold, provided the check of R3 passes.
- R5: On `exc_i` the saved word receives the old live word. The previous-set field (bits starting at 16) receives the old current set, the current set becomes 0, and the exception-mode bit (bit 2) becomes 1. This happens whatever the value of the interrupt-enable bit.
- R6: On `brk_i` the saved word, the previous-set field and the exception-mode bit are updated as in R5, and the current set is left unchanged.
- R7: On taking an interrupt the saved word receives the old live word, and the previous set receives the old current set. The current set becomes `irq_set_i`, the interrupt-enable bit becomes 0 and the interrupt-mode bit (bit 3) becomes 1. The nonmaskable-mode bit (bit 22) becomes 1 for a nonmaskable request and otherwise keeps its value.
- R8: A software write with `wr_sel_i` = 0 updates these fields of the live word: bit 0, bit 1 (user), bit 2, bit 3, the threshold, the previous set and bit 23. The current set and bit 22 ignore the write. The set fields hold only the bits needed for SETS-1, and every bit outside the fields reads 0.
- R9: A software write with `wr_sel_i` = 1 loads the saved word with the written data, keeping only the defined bits, the current set and bit 22 included.
- R10: `eret_i` copies the saved word into the live word at the next clock edge.
- R11: The events rank exc_i, then brk_i, then an accepted interrupt, then eret_i, then software writes. `irq_take_o` is 0 in any cycle in which `exc_i` or `brk_i` is 1.
- R12: A software write made in the same cycle as any hardware update has no effect on either word.
- R13: With HAS_MMU = 0, the user bit and the exception-mode bit always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_i | input | 1 | Noninterrupt exception strobe |
| brk_i | input | 1 | Break strobe |
| irq_req_i | input | 1 | External interrupt request valid |
| irq_lvl_i | input | LVL_W | Requested interrupt level |
| irq_set_i | input | SET_W | Requested register set |
| irq_nmi_i | input | 1 | Request is nonmaskable |
| eret_i | input | 1 | Return-from-exception strobe |
| wr_en_i | input | 1 | Software write enable |
| wr_sel_i | input | 1 | Write target: 0 live word, 1 saved word |
| wr_data_i | input | 32 | Software write data |
| status_o | output | 32 | Live status word |
| saved_o | output | 32 | Saved status word |
| irq_take_o | output | 1 | Interrupt accepted this cycle |

## Verification
The assertions assume that `irq_set_i` always names an implemented register set and that the strobes are plain one-cycle pulses sampled at the clock edge. They also assume that `irq_lvl_i` and `irq_set_i` are stable while a request is raised. The stimulus uses four register sets, so every set index is legal. It changes inputs only just after a falling edge. When the bench samples the decision without wanting an entry, it drops the request before the next rising edge.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int WORD_W = 32;
  localparam int SLOT_W = 6;   // room reserved for the level and set fields

  // bit positions of the status word (software visible)
  localparam int B_IE   = 0;
  localparam int B_USER = 1;
  localparam int B_EXC  = 2;
  localparam int B_IRQ  = 3;
  localparam int B_LVL  = 4;
  localparam int B_CUR  = B_LVL + SLOT_W;
  localparam int B_PREV = B_CUR + SLOT_W;
  localparam int B_NMI  = B_PREV + SLOT_W;
  localparam int B_SIE  = B_NMI + 1;

  localparam logic [WORD_W-1:0] RST_WORD = WORD_W'(1) << B_SIE;

  typedef enum logic [2:0] {
    EV_IDLE,
    EV_EXC,
    EV_BRK,
    EV_IRQ,
    EV_ERET,
    EV_WR_LIVE,
    EV_WR_SAVE
  } psr_ev_e;

  function automatic logic [WORD_W-1:0] ones_at(int lsb, int w);
    return ((WORD_W'(1) << w) - WORD_W'(1)) << lsb;
  endfunction

  // every bit that exists for the given configuration
  function automatic logic [WORD_W-1:0] legal_mask(int set_w, int lvl_w, bit mmu);
    logic [WORD_W-1:0] m;
    m = ones_at(B_IE, 1) | ones_at(B_IRQ, 1) | ones_at(B_NMI, 1) | ones_at(B_SIE, 1)
      | ones_at(B_LVL, lvl_w) | ones_at(B_CUR, set_w) | ones_at(B_PREV, set_w);
    if (mmu) m = m | ones_at(B_USER, 1) | ones_at(B_EXC, 1);
    return m;
  endfunction

  // bits that a software write to the live word may change
  function automatic logic [WORD_W-1:0] writable_mask(int set_w, int lvl_w, bit mmu);
    return legal_mask(set_w, lvl_w, mmu) & ~ones_at(B_CUR, set_w) & ~ones_at(B_NMI, 1);
  endfunction

endpackage

// File: rtl/psr_accept.sv
module psr_accept #(
  parameter int LVL_W = 6,
  parameter int SET_W = 2
) (
  input  logic             ie,
  input  logic             set_ie,
  input  logic [LVL_W-1:0] thr,
  input  logic [SET_W-1:0] cur_set,
  input  logic             req,
  input  logic             nmi,
  input  logic [LVL_W-1:0] lvl,
  input  logic [SET_W-1:0] req_set,
  output logic             ok
);

  logic lvl_ok;
  logic set_ok;

  always_comb begin
    lvl_ok = ie && (lvl > thr);
    set_ok = set_ie || (req_set != cur_set);
    ok     = req && (nmi || lvl_ok) && set_ok;
  end

endmodule

// File: rtl/psr_arbiter.sv
module psr_arbiter
  import psr_pkg::*;
(
  input  logic    exc,
  input  logic    brk,
  input  logic    irq_ok,
  input  logic    eret,
  input  logic    wr_en,
  input  logic    wr_sel,
  output logic    take,
  output psr_ev_e ev
);

  always_comb begin
    take = irq_ok && !exc && !brk;
    if (exc)         ev = EV_EXC;
    else if (brk)    ev = EV_BRK;
    else if (take)   ev = EV_IRQ;
    else if (eret)   ev = EV_ERET;
    else if (wr_en)  ev = wr_sel ? EV_WR_SAVE : EV_WR_LIVE;
    else             ev = EV_IDLE;
  end

endmodule

// File: rtl/psr_next.sv
module psr_next
  import psr_pkg::*;
#(
  parameter int LVL_W   = 6,
  parameter int SET_W   = 2,
  parameter bit HAS_MMU = 1'b1
) (
  input  psr_ev_e           ev,
  input  logic [WORD_W-1:0] st,
  input  logic [WORD_W-1:0] sv,
  input  logic [WORD_W-1:0] wdata,
  input  logic [SET_W-1:0]  req_set,
  input  logic              req_nmi,
  output logic [WORD_W-1:0] st_nx,
  output logic [WORD_W-1:0] sv_nx
);

  localparam logic [WORD_W-1:0] LEGAL = legal_mask(SET_W, LVL_W, HAS_MMU);
  localparam logic [WORD_W-1:0] WMASK = writable_mask(SET_W, LVL_W, HAS_MMU);

  logic [SET_W-1:0]  cur;
  logic [WORD_W-1:0] raw;

  always_comb begin
    cur   = st[B_CUR +: SET_W];
    raw   = st;
    sv_nx = sv;
    unique case (ev)
      EV_EXC: begin
        sv_nx                 = st;
        raw[B_PREV +: SET_W]  = cur;
        raw[B_CUR +: SET_W]   = '0;
        raw[B_EXC]            = 1'b1;
      end
      EV_BRK: begin
        sv_nx                 = st;
        raw[B_PREV +: SET_W]  = cur;
        raw[B_EXC]            = 1'b1;
      end
      EV_IRQ: begin
        sv_nx                 = st;
        raw[B_PREV +: SET_W]  = cur;
        raw[B_CUR +: SET_W]   = req_set;
        raw[B_IE]             = 1'b0;
        raw[B_IRQ]            = 1'b1;
        if (req_nmi) raw[B_NMI] = 1'b1;
      end
      EV_ERET:    raw   = sv;
      EV_WR_LIVE: raw   = (st & ~WMASK) | (wdata & WMASK);
      EV_WR_SAVE: sv_nx = wdata & LEGAL;
      default: ;
    endcase
    st_nx = raw & LEGAL;
  end

endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
#(
  parameter int SETS    = 4,     // number of register sets, at most 64
  parameter int LVL_W   = 6,     // interrupt level width, at most 6
  parameter bit HAS_MMU = 1'b1,
  localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exc_i,
  input  logic              brk_i,
  input  logic              irq_req_i,
  input  logic [LVL_W-1:0]  irq_lvl_i,
  input  logic [SET_W-1:0]  irq_set_i,
  input  logic              irq_nmi_i,
  input  logic              eret_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] saved_o,
  output logic              irq_take_o
);

  logic [WORD_W-1:0] st_q, sv_q, st_nx, sv_nx;
  logic              irq_ok;
  psr_ev_e           ev;

  psr_accept #(.LVL_W(LVL_W), .SET_W(SET_W)) u_accept (
    .ie      (st_q[B_IE]),
    .set_ie  (st_q[B_SIE]),
    .thr     (st_q[B_LVL +: LVL_W]),
    .cur_set (st_q[B_CUR +: SET_W]),
    .req     (irq_req_i),
    .nmi     (irq_nmi_i),
    .lvl     (irq_lvl_i),
    .req_set (irq_set_i),
    .ok      (irq_ok)
  );

  psr_arbiter u_arb (
    .exc    (exc_i),
    .brk    (brk_i),
    .irq_ok (irq_ok),
    .eret   (eret_i),
    .wr_en  (wr_en_i),
    .wr_sel (wr_sel_i),
    .take   (irq_take_o),
    .ev     (ev)
  );

  psr_next #(.LVL_W(LVL_W), .SET_W(SET_W), .HAS_MMU(HAS_MMU)) u_next (
    .ev      (ev),
    .st      (st_q),
    .sv      (sv_q),
    .wdata   (wr_data_i),
    .req_set (irq_set_i),
    .req_nmi (irq_nmi_i),
    .st_nx   (st_nx),
    .sv_nx   (sv_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= RST_WORD;
      sv_q <= '0;
    end else begin
      st_q <= st_nx;
      sv_q <= sv_nx;
    end
  end

  assign status_o = st_q;
  assign saved_o  = sv_q;

endmodule

// File: rtl/psr_unit_chk.sv
module psr_unit_chk
  import psr_pkg::*;
#(
  parameter int SETS    = 4,
  parameter int LVL_W   = 6,
  parameter bit HAS_MMU = 1'b1,
  localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              exc_i,
  input logic              brk_i,
  input logic              irq_req_i,
  input logic [LVL_W-1:0]  irq_lvl_i,
  input logic [SET_W-1:0]  irq_set_i,
  input logic              irq_nmi_i,
  input logic              eret_i,
  input logic [WORD_W-1:0] status_o,
  input logic [WORD_W-1:0] saved_o,
  input logic              irq_take_o
);

  localparam logic [WORD_W-1:0] LEGAL = legal_mask(SET_W, LVL_W, HAS_MMU);

  logic [SET_W-1:0] cur, prev;
  logic [LVL_W-1:0] thr;
  assign cur  = status_o[B_CUR +: SET_W];
  assign prev = status_o[B_PREV +: SET_W];
  assign thr  = status_o[B_LVL +: LVL_W];

  p_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (status_o == RST_WORD && saved_o == '0));

  p_maskable_r2: assert property (@(posedge clk) disable iff (rst)
    (irq_take_o && !irq_nmi_i) |-> (status_o[B_IE] && irq_lvl_i > thr));

  p_set_enable_r3: assert property (@(posedge clk) disable iff (rst)
    (irq_take_o && !status_o[B_SIE]) |-> (irq_set_i != cur));

  p_nmi_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (irq_req_i && irq_nmi_i && !exc_i && !brk_i && (status_o[B_SIE] || irq_set_i != cur))
      |-> irq_take_o);

  p_exc_entry_r5: assert property (@(posedge clk) disable iff (rst)
    exc_i |=> (saved_o == $past(status_o) && cur == '0 && prev == $past(cur)
               && (!HAS_MMU || status_o[B_EXC])));

  p_irq_entry_r7: assert property (@(posedge clk) disable iff (rst)
    irq_take_o |=> (cur == $past(irq_set_i) && status_o[B_IRQ] && !status_o[B_IE]
                    && saved_o == $past(status_o)));

  p_defined_bits_r8: assert property (@(posedge clk) disable iff (rst)
    ((status_o & ~LEGAL) == '0 && (saved_o & ~LEGAL) == '0));

  p_eret_r10: assert property (@(posedge clk) disable iff (rst)
    (eret_i && !exc_i && !brk_i && !irq_take_o) |=> (status_o == $past(saved_o)));

  p_exc_first_r11: assert property (@(posedge clk) disable iff (rst)
    (exc_i || brk_i) |-> !irq_take_o);

endmodule

bind psr_unit psr_unit_chk #(.SETS(SETS), .LVL_W(LVL_W), .HAS_MMU(HAS_MMU)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .exc_i      (exc_i),
  .brk_i      (brk_i),
  .irq_req_i  (irq_req_i),
  .irq_lvl_i  (irq_lvl_i),
  .irq_set_i  (irq_set_i),
  .irq_nmi_i  (irq_nmi_i),
  .eret_i     (eret_i),
  .status_o   (status_o),
  .saved_o    (saved_o),
  .irq_take_o (irq_take_o)
);

// File: tb/psr_unit_test.sv
`timescale 1ns/1ps
module psr_unit_test;

  localparam int SETS  = 4;
  localparam int LVL_W = 3;
  localparam int SET_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic             exc, brk, req, nmi, eret, wen, wsel;
  logic [LVL_W-1:0] lvl;
  logic [SET_W-1:0] rset;
  logic [31:0]      wdat;
  logic [31:0]      st, sv;
  logic             take;

  logic             n_exc, n_wen;
  logic [31:0]      n_wdat, n_st, n_sv;
  logic             n_take;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  psr_unit #(.SETS(SETS), .LVL_W(LVL_W), .HAS_MMU(1'b1)) uut (
    .clk(clk), .rst(rst), .exc_i(exc), .brk_i(brk), .irq_req_i(req),
    .irq_lvl_i(lvl), .irq_set_i(rset), .irq_nmi_i(nmi), .eret_i(eret),
    .wr_en_i(wen), .wr_sel_i(wsel), .wr_data_i(wdat),
    .status_o(st), .saved_o(sv), .irq_take_o(take)
  );

  psr_unit #(.SETS(SETS), .LVL_W(LVL_W), .HAS_MMU(1'b0)) uut_nommu (
    .clk(clk), .rst(rst), .exc_i(n_exc), .brk_i(1'b0), .irq_req_i(1'b0),
    .irq_lvl_i('0), .irq_set_i('0), .irq_nmi_i(1'b0), .eret_i(1'b0),
    .wr_en_i(n_wen), .wr_sel_i(1'b0), .wr_data_i(n_wdat),
    .status_o(n_st), .saved_o(n_sv), .irq_take_o(n_take)
  );

  // status word built from field values: bit0 ie, bit1 user, bit2 exc-mode,
  // bit3 irq-mode, level at 4, current set at 10, previous set at 16,
  // bit22 nonmaskable-mode, bit23 set-enable
  function automatic logic [31:0] mk(int ie, int u, int eh, int ih, int il,
                                     int cr, int pr, int nm, int si);
    return 32'(ie) | (32'(u) << 1) | (32'(eh) << 2) | (32'(ih) << 3)
         | (32'(il) << 4) | (32'(cr) << 10) | (32'(pr) << 16)
         | (32'(nm) << 22) | (32'(si) << 23);
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle();
    exc = 0; brk = 0; req = 0; nmi = 0; eret = 0; wen = 0; wsel = 0;
    lvl = '0; rset = '0; wdat = '0; n_exc = 0; n_wen = 0; n_wdat = '0;
  endtask

  // inputs were set just after a falling edge; let one rising edge pass
  task automatic cycle();
    @(negedge clk);
    idle();
  endtask

  task automatic wr_live(logic [31:0] d);
    @(negedge clk); wen = 1; wsel = 0; wdat = d; cycle();
  endtask

  task automatic wr_save(logic [31:0] d);
    @(negedge clk); wen = 1; wsel = 1; wdat = d; cycle();
  endtask

  task automatic irq(int l, int s, int n);
    @(negedge clk); req = 1; lvl = LVL_W'(l); rset = SET_W'(s); nmi = n[0];
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 live after reset", st, 32'h0080_0000);
    chk("R1 saved after reset", sv, 32'h0);
    chk("R1 take idle", 32'(take), 32'h0);

    // decision sweep over current set, enables, threshold, level, flag, set
    for (int c = 0; c < SETS; c++) begin
      wr_live(mk(0, 0, 0, 0, 0, 0, 0, 0, 1));
      irq(0, c, 1); cycle();
      for (int ie = 0; ie < 2; ie++)
        for (int si = 0; si < 2; si++)
          for (int th = 0; th < 8; th++) begin
            wr_live(mk(ie, 0, 0, 0, th, 0, 0, 0, si));
            for (int l = 0; l < 8; l++)
              for (int n = 0; n < 2; n++)
                for (int s = 0; s < SETS; s++) begin
                  logic exp;
                  irq(l, s, n);
                  #1;
                  exp = ((n == 1) || (ie == 1 && l > th)) && (si == 1 || s != c);
                  if (n == 1)                chk("R4 nonmaskable decision", 32'(take), 32'(exp));
                  else if (si == 0 && s == c) chk("R3 same-set refusal", 32'(take), 32'(exp));
                  else                        chk("R2 maskable decision", 32'(take), 32'(exp));
                  idle();
                end
          end
    end
    // state now: current set 3, nonmaskable-mode 1
    wr_live(32'hFFFF_FFFF);
    chk("R8 live write fields", st, mk(1, 1, 1, 1, 7, 3, 3, 1, 1));

    @(negedge clk); exc = 1; cycle();
    chk("R5 exc saved", sv, mk(1, 1, 1, 1, 7, 3, 3, 1, 1));
    chk("R5 exc live", st, mk(1, 1, 1, 1, 7, 0, 3, 1, 1));

    wr_live(mk(0, 0, 0, 0, 2, 0, 0, 0, 1));
    @(negedge clk); exc = 1; cycle();
    chk("R5 exc with enable low saved", sv, mk(0, 0, 0, 0, 2, 0, 0, 1, 1));
    chk("R5 exc with enable low live", st, mk(0, 0, 1, 0, 2, 0, 0, 1, 1));

    wr_save(32'hFFFF_FFFF);
    chk("R9 saved write mask", sv, mk(1, 1, 1, 1, 7, 3, 3, 1, 1));
    wr_save(mk(1, 0, 0, 0, 1, 1, 0, 0, 1));
    @(negedge clk); eret = 1; cycle();
    chk("R10 eret live", st, mk(1, 0, 0, 0, 1, 1, 0, 0, 1));
    chk("R10 eret saved kept", sv, mk(1, 0, 0, 0, 1, 1, 0, 0, 1));

    irq(4, 2, 0); #1;
    chk("R2 level above threshold", 32'(take), 32'h1);
    cycle();
    chk("R7 maskable saved", sv, mk(1, 0, 0, 0, 1, 1, 0, 0, 1));
    chk("R7 maskable live", st, mk(0, 0, 0, 1, 1, 2, 1, 0, 1));

    @(negedge clk); brk = 1; cycle();
    chk("R6 break saved", sv, mk(0, 0, 0, 1, 1, 2, 1, 0, 1));
    chk("R6 break live", st, mk(0, 0, 1, 1, 1, 2, 2, 0, 1));

    irq(0, 3, 1); #1;
    chk("R4 nonmaskable with enable low", 32'(take), 32'h1);
    cycle();
    chk("R7 nonmaskable saved", sv, mk(0, 0, 1, 1, 1, 2, 2, 0, 1));
    chk("R7 nonmaskable live", st, mk(0, 0, 1, 1, 1, 3, 2, 1, 1));

    irq(0, 1, 1); exc = 1; #1;
    chk("R11 take masked by exc", 32'(take), 32'h0);
    cycle();
    chk("R11 exc over irq live", st, mk(0, 0, 1, 1, 1, 0, 3, 1, 1));

    irq(0, 1, 1); brk = 1; #1;
    chk("R11 take masked by brk", 32'(take), 32'h0);
    cycle();
    chk("R11 brk over irq live", st, mk(0, 0, 1, 1, 1, 0, 0, 1, 1));

    @(negedge clk); exc = 1; wen = 1; wsel = 0; wdat = 32'hFFFF_FFFF; cycle();
    chk("R12 exc over live write", st, mk(0, 0, 1, 1, 1, 0, 0, 1, 1));
    chk("R12 exc saved", sv, mk(0, 0, 1, 1, 1, 0, 0, 1, 1));

    wr_live(mk(1, 1, 0, 0, 5, 0, 2, 0, 1));
    @(negedge clk); eret = 1; wen = 1; wsel = 1; wdat = 32'h0; cycle();
    chk("R12 eret over saved write saved", sv, mk(0, 0, 1, 1, 1, 0, 0, 1, 1));
    chk("R12 eret over saved write live", st, mk(0, 0, 1, 1, 1, 0, 0, 1, 1));

    @(negedge clk); n_wen = 1; n_wdat = 32'hFFFF_FFFF; cycle();
    chk("R13 write without mmu", n_st, mk(1, 0, 0, 1, 7, 0, 3, 0, 1));
    @(negedge clk); n_exc = 1; cycle();
    chk("R13 exc without mmu", n_st, mk(1, 0, 0, 1, 7, 0, 0, 0, 1));
    chk("R13 exc without mmu saved", n_sv, mk(1, 0, 0, 1, 7, 0, 3, 0, 1));

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule